// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Sync

This block produces the counting timeline for one PWM channel. A tick is derived from the system clock by two prescalers in series. A counter advances on each tick against a programmable period, counting up, counting down, or counting up and then down. It can also be told to hold its value. Downstream compare and action logic consumes the counter value, the direction flag and the zero and period strobes. That logic is not part of this block.

Several channels can run in lock-step. One global clock-sync enable gates every channel's prescaler, so all channels can start together. Each channel can also reload its counter from a phase value, either when a sync pulse arrives or when software forces one. A selectable sync output lets one channel drive the sync input of the next in a chain. Configuration goes in through a small write-only register port.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter reads 0, the direction flag is 0, both strobes are low, the mode is hold (11) and the sync output passes the sync input through (select 00).
- R2: While clk_sync_en is 0, no tick occurs and the counter holds. The prescaler restarts from zero, so the first tick comes D cycles after the enable rises, where D is the total divide.
- R3: A tick occurs once every D = H x K system clocks. H is set by control bits [4:2]: codes 0..7 give 1, 2, 4, 6, 8, 10, 12, 14. K is set by control bits [7:5]: codes 0..7 give 1, 2, 4, 8, 16, 32, 64, 128.
- R4: Mode 00 (up): each tick adds 1 to the counter. At a count equal to or above the period, the next tick wraps it to 0. The direction flag becomes 0.
- R5: Mode 01 (down): each tick subtracts 1 from the counter. At 0, the next tick reloads the period. The direction flag becomes 1.
- R6: Mode 10 (up-down): the counter climbs to the period and then descends to 0, so one full cycle is twice the period in ticks. The direction flag changes on the tick that turns the counter around.
- R7: Mode 11 (hold): the counter and direction flag keep their values and no strobe is raised.
- R8: A new mode applies from the next tick onward, and counting continues from the value the counter already holds.
- R9: zero_evt and period_evt are one-clock strobes. They are raised only in a cycle with a tick in a counting mode, when the counter equals 0 or the period respectively.
- R10: With phase enable (control bit 8) set, a clock edge that samples sync_in high loads the phase value into the counter. With phase enable clear, sync_in has no effect on the counter.
- R11: Writing control with bit 11 set forces a software sync. If the phase enable just written is 1, the counter loads the phase value on the second clock edge after the write. Otherwise the counter is left unchanged.
- R12: Sync output select (control bits [10:9]) chooses the sync output: 00 passes sync_in through, 01 follows zero_evt, 10 pulses on a counting tick where the counter equals compare B, and 11 holds it low.
- R13: Register write addresses: 0 is control (mode in bits [1:0]), 1 is the period, 2 is the phase value, and 3 is compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sync_en | input | 1 | Global enable shared by all channels; 0 stops ticking |
| sync_in | input | 1 | Sync pulse from the previous channel in the chain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CW | Register write data |
| count | output | CW | Current counter value |
| dir_down | output | 1 | 1 while counting down |
| zero_evt | output | 1 | Counter-equals-zero strobe |
| period_evt | output | 1 | Counter-equals-period strobe |
| sync_out | output | 1 | Selected sync output for the next channel |

## Verification
The bench uses the default counter width of 16 bits. It programs periods of 3 to 5, so every wrap and turnaround occurs within a few dozen ticks. It selects the divide codes that give the smallest divide (1), a mixed product (8), the largest first-stage divide (14) and the largest second-stage divide (128). This puts each prescaler extreme within a few hundred cycles. It moves the counter through each mode in turn without resetting it, and the sync tests are run with ticking stopped, so any change in the count can only come from a phase load.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  // Width of the prescaler count; the largest divide is 14 * 128 = 1792.
  localparam int DIV_W = 11;

  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDOWN = 2'b10,
    MODE_HOLD   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'b00,
    SO_ZERO = 2'b01,
    SO_CMPB = 2'b10,
    SO_OFF  = 2'b11
  } sync_sel_e;

  // Control register; the force-sync bit (11) is a strobe and is not stored.
  typedef struct packed {
    sync_sel_e  sync_sel;  // [10:9]
    logic       phase_en;  // [8]
    logic [2:0] ck_code;   // [7:5]
    logic [2:0] hs_code;   // [4:2]
    cnt_mode_e  mode;      // [1:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RESET = '{sync_sel: SO_PASS, phase_en: 1'b0,
                                   ck_code: 3'd0, hs_code: 3'd1,
                                   mode: MODE_HOLD};

  // First-stage factor: code 0 is 1, otherwise twice the code.
  function automatic logic [DIV_W-1:0] hs_factor(input logic [2:0] code);
    return (code == 3'd0) ? DIV_W'(1) : (DIV_W'(code) << 1);
  endfunction

  // Second-stage factor: a power of two.
  function automatic logic [DIV_W-1:0] ck_factor(input logic [2:0] code);
    return DIV_W'(1) << code;
  endfunction

  // Total divide between ticks.
  function automatic logic [DIV_W-1:0] tick_divide(input logic [2:0] hs,
                                                   input logic [2:0] ck);
    logic [2*DIV_W-1:0] prod;
    prod = {{DIV_W{1'b0}}, hs_factor(hs)} * {{DIV_W{1'b0}}, ck_factor(ck)};
    return prod[DIV_W-1:0];
  endfunction

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output ctrl_t         ctrl,
  output logic [CW-1:0] period,
  output logic [CW-1:0] phase,
  output logic [CW-1:0] cmpb,
  output logic          sw_sync
);

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_PRD   = 2'd1;
  localparam logic [1:0] A_PHASE = 2'd2;
  localparam logic [1:0] A_CMPB  = 2'd3;
  localparam int FORCE_BIT = CTRL_W;

  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RESET;
      period  <= '0;
      phase   <= '0;
      cmpb    <= '0;
      sw_sync <= 1'b0;
    end else begin
      // The strobe is registered, so it sees the phase enable written with it.
      sw_sync <= wr_ctrl && wr_data[FORCE_BIT];
      if (wr_ctrl)                        ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == A_PRD)      period <= wr_data;
      if (wr_en && wr_addr == A_PHASE)    phase  <= wr_data;
      if (wr_en && wr_addr == A_CMPB)     cmpb   <= wr_data;
    end
  end

endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
  import ptb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] hs_code,
  input  logic [2:0] ck_code,
  output logic       tick
);

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] div_m1;

  assign div_m1 = tick_divide(hs_code, ck_code) - DIV_W'(1);
  // ">=" recovers in one step if the divide shrinks mid-count.
  assign tick   = en && (pcnt >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt <= '0;
    else if (!en || tick)  pcnt <= '0;
    else                   pcnt <= pcnt + DIV_W'(1);
  end

  // Counting starts from zero when enabled: a tick on the first enabled cycle
  // is only possible with a divide of one.
  p_first_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (tick == (div_m1 == '0)));

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  cnt_mode_e     mode,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] phase,
  input  logic          load,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          step,
  output logic          zero_hit,
  output logic          period_hit
);

  localparam logic [CW-1:0] ONE = CW'(1);

  assign step       = tick && (mode != MODE_HOLD);
  assign zero_hit   = step && (cnt_q == '0);
  assign period_hit = step && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (load) begin
      cnt_q <= phase;
    end else if (step) begin
      case (mode)
        MODE_UP: begin
          cnt_q <= (cnt_q >= period) ? '0 : cnt_q + ONE;
          dir_q <= 1'b0;
        end
        MODE_DOWN: begin
          cnt_q <= (cnt_q == '0) ? period : cnt_q - ONE;
          dir_q <= 1'b1;
        end
        MODE_UPDOWN: begin
          if (!dir_q) begin
            if (cnt_q >= period) begin
              dir_q <= 1'b1;
              cnt_q <= (cnt_q == '0) ? '0 : cnt_q - ONE;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              dir_q <= 1'b0;
              cnt_q <= (period == '0) ? '0 : ONE;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> ($stable(cnt_q) && $stable(dir_q)));

  p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UP && cnt_q >= period && !load) |=> (cnt_q == '0));

  p_down_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_DOWN && cnt_q == '0 && !load) |=> (cnt_q == $past(period)));

  p_updown_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UPDOWN && !dir_q && cnt_q >= period && !load) |=> dir_q);

  p_hold_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !load) |=> $stable(cnt_q));

  p_phase_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(phase)));

endmodule

// File: rtl/ptb_sync_out.sv
module ptb_sync_out
  import ptb_pkg::*;
#(
  parameter int CW = 16
) (
  input  sync_sel_e     sel,
  input  logic          sync_in,
  input  logic          zero_hit,
  input  logic          step,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmpb,
  output logic          sync_out
);

  logic cmpb_hit;
  assign cmpb_hit = step && (count == cmpb);

  always_comb begin
    case (sel)
      SO_PASS: sync_out = sync_in;
      SO_ZERO: sync_out = zero_hit;
      SO_CMPB: sync_out = cmpb_hit;
      default: sync_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import ptb_pkg::*;
#(
  parameter int CW = 16  // must be at least 12 to hold the control word
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_sync_en,
  input  logic          sync_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic          dir_down,
  output logic          zero_evt,
  output logic          period_evt,
  output logic          sync_out
);

  ctrl_t         ctrl;
  logic [CW-1:0] period, phase, cmpb;
  logic          sw_sync;
  logic          tick;
  logic          step;
  logic          load;

  ptb_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .period(period), .phase(phase),
    .cmpb(cmpb), .sw_sync(sw_sync)
  );

  ptb_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .en(clk_sync_en),
    .hs_code(ctrl.hs_code), .ck_code(ctrl.ck_code), .tick(tick)
  );

  // Phase load: hardware or software sync, gated by phase enable.
  assign load = ctrl.phase_en && (sync_in || sw_sync);

  ptb_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctrl.mode),
    .period(period), .phase(phase), .load(load),
    .cnt_q(count), .dir_q(dir_down), .step(step),
    .zero_hit(zero_evt), .period_hit(period_evt)
  );

  ptb_sync_out #(.CW(CW)) u_sync (
    .sel(ctrl.sync_sel), .sync_in(sync_in), .zero_hit(zero_evt),
    .step(step), .count(count), .cmpb(cmpb), .sync_out(sync_out)
  );

  p_strobe_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt || period_evt) |-> tick);

  p_sync_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.sync_sel == SO_ZERO) |-> (sync_out == zero_evt));

  p_sync_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.sync_sel == SO_OFF) |-> !sync_out);

  p_sw_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_sync && ctrl.phase_en) |=> (count == $past(phase)));

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_sync_en = 1'b0;
  logic          sync_in = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count;
  logic          dir_down, zero_evt, period_evt, sync_out;

  pwm_timebase #(.CW(CW)) i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .clk_sync_en(clk_sync_en), .sync_in(sync_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .dir_down(dir_down), .zero_evt(zero_evt), .period_evt(period_evt),
    .sync_out(sync_out)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    cnt;
    bit    dir;
    bit    z;
    bit    p;
    bit    so;
    string tag;
  } exp_t;

  exp_t q[$];

  // Bench model state (mode codes: 0 up, 1 down, 2 up-down, 3 hold).
  int m_cnt = 0, m_dir = 0, m_mode = 3, m_hs = 1, m_ck = 0;
  int m_prd = 0, m_cmpb = 0, m_sel = 0, m_phen = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int b_hs(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 10; 6: return 12; default: return 14;
    endcase
  endfunction

  function automatic int b_ck(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4: return 16; 5: return 32; 6: return 64; default: return 128;
    endcase
  endfunction

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Control word: [1:0] mode, [4:2] hs, [7:5] ck, [8] phase en, [10:9] sel, [11] force.
  task automatic setcfg(int mode, int hs, int ck, int phen, int sel, int frc);
    m_mode = mode; m_hs = hs; m_ck = ck; m_phen = phen; m_sel = sel;
    wr(0, mode | (hs << 2) | (ck << 5) | (phen << 8) | (sel << 9) | (frc << 11));
  endtask

  task automatic model_step();
    case (m_mode)
      0: begin m_cnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1; m_dir = 0; end
      1: begin m_cnt = (m_cnt == 0) ? m_prd : m_cnt - 1; m_dir = 1; end
      2: begin
        if (m_dir == 0) begin
          if (m_cnt >= m_prd) begin m_dir = 1; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_dir = 0; m_cnt = (m_prd == 0) ? 0 : 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      default: ;
    endcase
  endtask

  // Driver: predicts n cycles of enabled operation, queues them, then runs.
  task automatic run(int n, string tag);
    int d;
    d = b_hs(m_hs) * b_ck(m_ck);
    @(negedge clk);
    for (int j = 1; j <= n; j++) begin
      exp_t e;
      bit tnext, live;
      if (j % d == 0 && m_mode != 3) model_step();
      tnext = ((j + 1) % d == 0);
      live  = tnext && (m_mode != 3);
      e.cnt = m_cnt; e.dir = m_dir[0];
      e.z   = live && (m_cnt == 0);
      e.p   = live && (m_cnt == m_prd);
      case (m_sel)
        1: e.so = e.z;
        2: e.so = live && (m_cnt == m_cmpb);
        default: e.so = 1'b0;
      endcase
      e.tag = tag;
      q.push_back(e);
    end
    clk_sync_en = 1'b1;
    while (q.size() > 0) @(negedge clk);
    clk_sync_en = 1'b0;
  endtask

  // Monitor: samples a quarter period after each rising edge.
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " count"},      int'(count),      e.cnt);
      chk({e.tag, " dir"},        int'(dir_down),   int'(e.dir));
      chk({e.tag, " zero_evt R9"},   int'(zero_evt),   int'(e.z));
      chk({e.tag, " period_evt R9"}, int'(period_evt), int'(e.p));
      chk({e.tag, " sync_out R12"},  int'(sync_out),   int'(e.so));
    end
  end

  bit done = 1'b0;

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dir_down), 0);
    chk("R1 zero_evt", int'(zero_evt), 0);
    chk("R1 period_evt", int'(period_evt), 0);
    sync_in = 1'b1; #1;
    chk("R1 R12 pass-through", int'(sync_out), 1);
    @(negedge clk); sync_in = 1'b0;
    chk("R1 R10 sync ignored", int'(count), 0);

    // R7 hold is the reset mode: enabled ticking leaves everything still
    run(10, "R1 R7 hold");

    // R13 period at 1, compare B at 3
    wr(1, 4); m_prd = 4;
    wr(3, 2); m_cmpb = 2;
    setcfg(0, 0, 0, 0, 1, 0);
    // R2 gated: no counting with clk_sync_en low
    repeat (8) @(negedge clk);
    chk("R2 gated count", int'(count), 0);
    chk("R2 gated strobe", int'(zero_evt), 0);

    run(12, "R4 up");
    wr(1, 3); m_prd = 3;
    setcfg(0, 2, 1, 0, 2, 0);          // divide 4 * 2
    run(40, "R3 div8");
    setcfg(0, 7, 0, 0, 3, 0);          // divide 14
    run(45, "R3 div14");
    setcfg(0, 0, 7, 0, 1, 0);          // divide 128
    run(260, "R3 div128 R2");

    wr(1, 5); m_prd = 5;
    setcfg(1, 0, 0, 0, 1, 0);
    run(14, "R5 R8 down");
    wr(1, 3); m_prd = 3;
    setcfg(2, 1, 0, 0, 2, 0);          // divide 2
    run(30, "R6 R8 updown");
    setcfg(3, 0, 0, 0, 1, 0);
    run(6, "R7 hold");

    // R10 phase load by sync_in
    wr(2, 7);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    chk("R10 phase disabled", int'(count), m_cnt);
    setcfg(3, 0, 0, 1, 0, 0);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    chk("R10 R13 phase load", int'(count), 7);

    // R11 software sync
    wr(2, 2);
    setcfg(3, 0, 0, 1, 0, 1);
    @(negedge clk);
    chk("R11 forced load", int'(count), 2);
    wr(2, 9);
    setcfg(3, 0, 0, 0, 0, 1);
    @(negedge clk); @(negedge clk);
    chk("R11 forced ignored", int'(count), 2);

    // R12 disabled output
    setcfg(3, 0, 0, 0, 3, 0);
    @(negedge clk); sync_in = 1'b1; #1;
    chk("R12 output off", int'(sync_out), 0);
    @(negedge clk); sync_in = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule